// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block decides, for one eight-line interrupt controller, whether an interrupt should be raised and which physical line wins. The caller owns the request, mask and in-service registers and presents them on the inputs each cycle. It also presents a rotation offset and three mode flags. The block registers its decision once per clock. The result can drive the controller's interrupt output and feed the acknowledge logic that sits outside this block.

Priority is relative. A request is first qualified by the mask. Both the qualified requests and the in-service bits are then ranked on a ring that starts at the line named by the rotation offset. A request is granted only if it ranks strictly above the best in-service level. Two modes can shrink the in-service set before that comparison. One drops in-service bits that are currently masked. The other, on a master unit, drops the cascade line.

Top module: `prio_resolver`

## Requirements
- R1: While `rst_n` is low, `irq_o` is 0 and `line_o` is 0.
- R2: Only lines set in `req_i` and clear in `mask_i` are candidates. A masked request never wins.
- R3: Priority position p belongs to physical line (p + `rot_i`) mod 8. Position 0 is the highest. Among the candidates, the one at the lowest position wins.
- R4: When no line is a candidate, `irq_o` is 0.
- R5: A candidate is granted only if its position is strictly lower than the position of the highest-ranked effective in-service line. An equal position does not grant.
- R6: When the effective in-service set is empty, any candidate is granted.
- R7: When `spec_mask_i` is 1, in-service lines that are also set in `mask_i` are left out of the effective in-service set. When it is 0, they count.
- R8: When `nest_i` and `master_i` are both 1, in-service line 2 is left out of the effective in-service set. In every other combination of the two flags, it counts.
- R9: `line_o` gives the winning physical line whenever `irq_o` is 1. While `irq_o` is 0, `line_o` keeps the last line that won.
- R10: The outputs reflect the inputs sampled at the previous rising clock edge. The latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request vector, one bit per physical line |
| mask_i | input | 8 | Mask vector, 1 = line masked |
| isr_i | input | 8 | In-service vector |
| rot_i | input | 3 | Line that holds priority position 0 |
| spec_mask_i | input | 1 | Drop masked in-service bits from the current level |
| nest_i | input | 1 | Special nesting: ignore the cascade in-service bit on a master |
| master_i | input | 1 | 1 = this unit is the master of a cascade |
| irq_o | output | 1 | Interrupt should be raised |
| line_o | output | 3 | Winning physical line |

## Verification
The assertions assume that every input is driven to a known value in each cycle that follows reset. They compare the registered outputs against the inputs from one clock earlier, which the checker captures itself. They also assume the cascade line is line 2. The bench changes the inputs only on falling edges and keeps them steady across each rising edge. It reads the outputs one full cycle after each change. Beyond the directed scenarios, it runs a stream of random vectors through every rotation and mode combination and compares each result against a priority model written into the bench.

// File: rtl/prio_pkg.sv
package prio_pkg;

  // mode flags that shape the effective in-service set
  typedef struct packed {
    logic spec_mask;
    logic nest;
    logic master;
  } prio_mode_t;

endpackage

// File: rtl/prio_rotate.sv
// Rotates a vector right by an offset so that bit p of the result is
// bit (p + off) mod N of the input.
module prio_rotate #(
  parameter int N = 8,
  localparam int OW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [OW-1:0] off_i,
  output logic [N-1:0]  rot_o
);

  logic [2*N-1:0] doubled;
  logic [2*N-1:0] shifted;

  assign doubled = {vec_i, vec_i};
  assign shifted = doubled >> off_i;
  assign rot_o   = shifted[N-1:0];

endmodule

// File: rtl/prio_ffs.sv
// Finds the lowest set bit. Returns N when no bit is set.
module prio_ffs #(
  parameter int N = 8,
  localparam int PW = $clog2(N) + 1
) (
  input  logic [N-1:0]  vec_i,
  output logic [PW-1:0] pos_o
);

  always_comb begin
    pos_o = PW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) pos_o = PW'(i);
    end
  end

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int NLINES    = 8,
  parameter int CASC_LINE = 2,
  localparam int LW = $clog2(NLINES),
  localparam int PW = LW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req_i,
  input  logic [NLINES-1:0] mask_i,
  input  logic [NLINES-1:0] isr_i,
  input  logic [LW-1:0]     rot_i,
  input  logic              spec_mask_i,
  input  logic              nest_i,
  input  logic              master_i,
  output logic              irq_o,
  output logic [LW-1:0]     line_o
);
  import prio_pkg::*;

  localparam logic [NLINES-1:0] CASC_BIT = NLINES'(1) << CASC_LINE;

  prio_mode_t        mode;
  logic [NLINES-1:0] cand_vec;
  logic [NLINES-1:0] isr_eff;
  logic [NLINES-1:0] cand_rot;
  logic [NLINES-1:0] isr_rot;
  logic [PW-1:0]     cand_pos;
  logic [PW-1:0]     cur_pos;
  logic              raise_d;
  logic [LW-1:0]     line_d;
  logic              irq_q;
  logic [LW-1:0]     line_q;

  assign mode = '{spec_mask: spec_mask_i, nest: nest_i, master: master_i};

  // qualify requests and shape the in-service set
  always_comb begin
    cand_vec = req_i & ~mask_i;
    isr_eff  = isr_i;
    if (mode.spec_mask) isr_eff = isr_eff & ~mask_i;
    if (mode.nest && mode.master) isr_eff = isr_eff & ~CASC_BIT;
  end

  prio_rotate #(.N(NLINES)) i_rot_cand (
    .vec_i (cand_vec),
    .off_i (rot_i),
    .rot_o (cand_rot)
  );

  prio_rotate #(.N(NLINES)) i_rot_isr (
    .vec_i (isr_eff),
    .off_i (rot_i),
    .rot_o (isr_rot)
  );

  prio_ffs #(.N(NLINES)) i_ffs_cand (
    .vec_i (cand_rot),
    .pos_o (cand_pos)
  );

  prio_ffs #(.N(NLINES)) i_ffs_isr (
    .vec_i (isr_rot),
    .pos_o (cur_pos)
  );

  // next-state: grant only on strict outranking; map position back to a line
  always_comb begin
    raise_d = (cand_pos < cur_pos);
    line_d  = cand_pos[LW-1:0] + rot_i;
  end

  // register stage; the line register is enabled only by a grant
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      line_q <= '0;
    end else begin
      irq_q <= raise_d;
      if (raise_d) line_q <= line_d;
    end
  end

  assign irq_o  = irq_q;
  assign line_o = line_q;

endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int NLINES    = 8,
  parameter int CASC_LINE = 2,
  localparam int LW = $clog2(NLINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] req_i,
  input logic [NLINES-1:0] mask_i,
  input logic [NLINES-1:0] isr_i,
  input logic [LW-1:0]     rot_i,
  input logic              spec_mask_i,
  input logic              nest_i,
  input logic              master_i,
  input logic              irq_o,
  input logic [LW-1:0]     line_o
);

  logic              seen_q;
  logic [NLINES-1:0] cand_q;
  logic [NLINES-1:0] isr_q;
  logic [LW-1:0]     rot_q;
  logic              smm_q;
  logic              nst_q;
  logic              mst_q;
  logic              top_blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cand_q <= '0;
      isr_q  <= '0;
      rot_q  <= '0;
      smm_q  <= 1'b0;
      nst_q  <= 1'b0;
      mst_q  <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      cand_q <= req_i & ~mask_i;
      isr_q  <= isr_i;
      rot_q  <= rot_i;
      smm_q  <= spec_mask_i;
      nst_q  <= nest_i;
      mst_q  <= master_i;
    end
  end

  assign top_blocked = isr_q[rot_q] && !smm_q &&
                       !(nst_q && mst_q && (int'(rot_q) == CASC_LINE));

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!irq_o && line_o == '0); // R1
    end
  end

  AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && irq_o) |-> cand_q[line_o]); // R2

  AST_FREE_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && cand_q[rot_q] && isr_q == '0) |-> (irq_o && line_o == rot_q)); // R3

  AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && cand_q == '0) |-> !irq_o); // R4

  AST_TOP_SLOT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && top_blocked) |-> !irq_o); // R5

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !irq_o) |-> $stable(line_o)); // R9

endmodule

bind prio_resolver prio_resolver_chk #(.NLINES(NLINES), .CASC_LINE(CASC_LINE)) i_prio_resolver_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .mask_i      (mask_i),
  .isr_i       (isr_i),
  .rot_i       (rot_i),
  .spec_mask_i (spec_mask_i),
  .nest_i      (nest_i),
  .master_i    (master_i),
  .irq_o       (irq_o),
  .line_o      (line_o)
);

// File: tb/test_prio_resolver.sv
module test_prio_resolver;

  logic       clk;
  logic       rst_n;
  logic [7:0] req_i, mask_i, isr_i;
  logic [2:0] rot_i;
  logic       spec_mask_i, nest_i, master_i;
  logic       irq_o;
  logic [2:0] line_o;

  int checks;
  int errors;
  logic [2:0] last_line;

  prio_resolver i_prio_resolver (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i), .isr_i(isr_i),
    .rot_i(rot_i), .spec_mask_i(spec_mask_i), .nest_i(nest_i),
    .master_i(master_i), .irq_o(irq_o), .line_o(line_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference ranking on the ring starting at rot
  function automatic int rank(input logic [7:0] v, input logic [2:0] rot);
    for (int p = 0; p < 8; p++) begin
      if (v[(p + int'(rot)) % 8]) return p;
    end
    return 8;
  endfunction

  function automatic void model(input logic [7:0] rq, input logic [7:0] mk,
                                input logic [7:0] is, input logic [2:0] rot,
                                input logic sm, input logic ns, input logic ms,
                                output logic ex_irq, output logic [2:0] ex_line);
    logic [7:0] eff;
    int cp, ip;
    eff = is;
    if (sm) eff = eff & ~mk;
    if (ns && ms) eff[2] = 1'b0;
    cp = rank(rq & ~mk, rot);
    ip = rank(eff, rot);
    ex_irq  = (cp < ip);
    ex_line = 3'((cp + int'(rot)) % 8);
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, read one full cycle later
  task automatic apply(input logic [7:0] rq, input logic [7:0] mk, input logic [7:0] is,
                       input logic [2:0] rot, input logic sm, input logic ns, input logic ms);
    @(negedge clk);
    req_i = rq; mask_i = mk; isr_i = is; rot_i = rot;
    spec_mask_i = sm; nest_i = ns; master_i = ms;
    @(negedge clk);
  endtask

  task automatic apply_and_compare(input string tag, input logic [7:0] rq, input logic [7:0] mk,
                                   input logic [7:0] is, input logic [2:0] rot,
                                   input logic sm, input logic ns, input logic ms);
    logic ei;
    logic [2:0] el;
    model(rq, mk, is, rot, sm, ns, ms, ei, el);
    apply(rq, mk, is, rot, sm, ns, ms);
    check({tag, " irq"}, {3'b0, irq_o}, {3'b0, ei});
    if (ei) begin
      check({tag, " line"}, {1'b0, line_o}, {1'b0, el});
      last_line = el;
    end else begin
      check({tag, " hold R9"}, {1'b0, line_o}, {1'b0, last_line});
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    req_i = 8'hFF; mask_i = 8'h00; isr_i = 8'h00; rot_i = 3'd0;
    spec_mask_i = 1'b0; nest_i = 1'b0; master_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset irq", {3'b0, irq_o}, 4'd0);
    check("R1 reset line", {1'b0, line_o}, 4'd0);
    req_i = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    last_line = 3'd0;
  endtask

  task automatic t_masking;
    apply_and_compare("R2 masked only", 8'h10, 8'h10, 8'h00, 3'd0, 0, 0, 0);
    apply_and_compare("R2 skip masked", 8'h0C, 8'h04, 8'h00, 3'd0, 0, 0, 0);
    check("R2 line3", {1'b0, line_o}, 4'd3);
  endtask

  task automatic t_rotation;
    apply_and_compare("R3 rot5", 8'h44, 8'h00, 8'h00, 3'd5, 0, 0, 0);
    check("R3 rot5 line6", {1'b0, line_o}, 4'd6);
    apply_and_compare("R3 rot7", 8'h44, 8'h00, 8'h00, 3'd7, 0, 0, 0);
    check("R3 rot7 line2", {1'b0, line_o}, 4'd2);
    apply_and_compare("R3 rot0 low", 8'h81, 8'h00, 8'h00, 3'd0, 0, 0, 0);
    check("R3 rot0 line0", {1'b0, line_o}, 4'd0);
  endtask

  task automatic t_empty;
    apply_and_compare("R4 empty", 8'h00, 8'h00, 8'h00, 3'd3, 0, 0, 0);
    check("R4 no irq", {3'b0, irq_o}, 4'd0);
  endtask

  task automatic t_strict;
    apply_and_compare("R5 equal", 8'h20, 8'h00, 8'h20, 3'd0, 0, 0, 0);
    check("R5 equal none", {3'b0, irq_o}, 4'd0);
    apply_and_compare("R5 higher", 8'h10, 8'h00, 8'h20, 3'd0, 0, 0, 0);
    check("R5 higher line4", {1'b0, line_o}, 4'd4);
    apply_and_compare("R6 no isr", 8'h80, 8'h00, 8'h00, 3'd0, 0, 0, 0);
    check("R6 irq", {3'b0, irq_o}, 4'd1);
  endtask

  task automatic t_specmask;
    apply_and_compare("R7 off", 8'h10, 8'h02, 8'h02, 3'd0, 0, 0, 0);
    check("R7 off none", {3'b0, irq_o}, 4'd0);
    apply_and_compare("R7 on", 8'h10, 8'h02, 8'h02, 3'd0, 1, 0, 0);
    check("R7 on irq", {3'b0, irq_o}, 4'd1);
  endtask

  task automatic t_nest;
    apply_and_compare("R8 master", 8'h08, 8'h00, 8'h04, 3'd0, 0, 1, 1);
    check("R8 master irq", {3'b0, irq_o}, 4'd1);
    apply_and_compare("R8 slave", 8'h08, 8'h00, 8'h04, 3'd0, 0, 1, 0);
    check("R8 slave none", {3'b0, irq_o}, 4'd0);
    apply_and_compare("R8 no nest", 8'h08, 8'h00, 8'h04, 3'd0, 0, 0, 1);
    check("R8 no nest none", {3'b0, irq_o}, 4'd0);
  endtask

  task automatic t_latency;
    // R10: a new grant appears after exactly one edge, not before
    @(negedge clk);
    req_i = 8'h40; mask_i = 8'h00; isr_i = 8'h00; rot_i = 3'd0;
    spec_mask_i = 0; nest_i = 0; master_i = 0;
    #1;
    check("R10 not yet", {1'b0, line_o}, {1'b0, last_line});
    @(negedge clk);
    check("R10 one cycle", {1'b0, line_o}, 4'd6);
    last_line = 3'd6;
  endtask

  task automatic t_random;
    for (int k = 0; k < 3000; k++) begin
      apply_and_compare("R3 R5 random", 8'($urandom), 8'($urandom), 8'($urandom & $urandom),
                        3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    t_reset();
    t_masking();
    t_rotation();
    t_empty();
    t_strict();
    t_specmask();
    t_nest();
    t_latency();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule